// File: doc/BRIEF.md
# ULPI Link-Side Bus Controller

This block sits on the link side of an 8-bit ULPI connection to an external USB transceiver and runs entirely on the 60 MHz clock that the transceiver supplies. It drives the stop line and watches the direction and next lines. It handles the shared data bus through separate input, output and output-enable signals, so the pad ring can build the tristate buffer. On the user side there is a byte-stream transmit port with valid, ready and last, and a receive port that gives one byte per valid pulse.

A reset gate sits in front of the bus logic. Reset can come from a hardware input or from a software control bit. While either one is asserted, and until enough clock edges have been counted after both are released, the bus logic stays in reset. During that time it holds the stop line high, so the transceiver sees the request and starts its clock.

Each change of bus direction is followed by one turnaround cycle. In that cycle the link neither drives nor samples the bus. If the transceiver takes the bus during a transmit, the transmit is dropped and an abort pulse is raised.

Top module: `ulpi_link`

## Requirements
- R1: `core_rst_done` is 0 in the cycle after any cycle in which a reset request is sampled high. It rises after the 12th rising clock edge at which both requests are sampled low.
- R2: Asserting either `hw_rst_req` or `sw_rst_req`, even for one cycle, restarts the 12-edge count. A request while `core_rst_done` is 1 clears it on the next edge.
- R3: `phy_stp` is 1 in every cycle in which `core_rst_done` is 0.
- R4: `dat_oe` is 0 in every cycle in which `phy_dir` is 1. It is also 0 in the one turnaround cycle in which `phy_dir` is 0 but was 1 at the previous edge.
- R5: When the link owns the bus (`phy_dir` 0 now and at the previous edge) and no transmit is in progress, `dat_oe` is 1 and `dat_o` is 8'h00.
- R6: When `tx_valid` is sampled high while the link owns the bus, a transmit starts in the next cycle and `dat_o` shows `tx_data`. During the transmit, `tx_ready` equals `phy_nxt`, and a byte is taken at each edge where `tx_valid` and `tx_ready` are both 1.
- R7: After the byte marked by `tx_last` is taken, `phy_stp` is 1 for exactly the next cycle, with `dat_o` at 8'h00. It is 0 in the cycle after that.
- R8: If `phy_dir` is 1 during a transmit, `tx_ready` and `dat_oe` are 0 in that cycle. `tx_abort` is 1 for exactly the next cycle, the transmit ends without a stop pulse, and `dat_o` returns to 8'h00.
- R9: When `phy_dir` is sampled 1 at an edge and was also 1 at the previous edge, and `phy_nxt` is 1, `rx_valid` is 1 in the following cycle and `rx_data` holds the sampled `dat_i`. The turnaround cycle after `phy_dir` rises captures nothing.
- R10: When `phy_dir` is sampled 0, `phy_nxt` and `dat_i` are ignored: `rx_valid` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock supplied by the transceiver (60 MHz) |
| hw_rst_req | input | 1 | Hardware reset request, active high |
| sw_rst_req | input | 1 | Software reset request bit, active high |
| phy_dir | input | 1 | Bus direction: 1 means the transceiver owns the bus |
| phy_nxt | input | 1 | Byte accepted (link sending) or byte present (transceiver sending) |
| phy_stp | output | 1 | Stop line to the transceiver |
| dat_i | input | 8 | Data bus value seen at the pads |
| dat_o | output | 8 | Data bus value driven by the link |
| dat_oe | output | 1 | Output enable for the data bus pads |
| tx_data | input | 8 | Transmit byte |
| tx_valid | input | 1 | Transmit byte is valid |
| tx_last | input | 1 | Transmit byte ends the stream |
| tx_ready | output | 1 | Transmit byte taken this cycle |
| tx_abort | output | 1 | One-cycle pulse: transmit dropped because the bus was taken |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle pulse: `rx_data` holds a new byte |
| core_rst_done | output | 1 | Bus logic is out of reset |

## Verification
The assertions assume the user holds `tx_valid`, `tx_data` and `tx_last` steady from the start of a transmit until its last byte is taken. They also assume a reset request is raised at power-up, so the edge counter starts from a known value. The stimulus keeps the transmit inputs fixed between accepted bytes and raises `hw_rst_req` from time zero. It draws `phy_dir` and `phy_nxt` freely only while no transmit is pending, so that the receive and turnaround checks see every pattern of direction changes.

// File: rtl/ulpi_link_pkg.sv
package ulpi_link_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_SEND = 2'd1,
        TX_STOP = 2'd2
    } tx_state_e;

    typedef struct packed {
        logic              dir;
        logic              nxt;
        logic [BYTE_W-1:0] data;
    } phy_side_t;

    // link may drive only when the transceiver has left the bus for a full cycle
    function automatic logic bus_owned(input logic dir_now, input logic dir_prev);
        return !dir_now && !dir_prev;
    endfunction

endpackage

// File: rtl/ulpi_rst_gate.sv
module ulpi_rst_gate #(
    parameter int MIN_CYC = 12
) (
    input  logic clk,
    input  logic hw_req,
    input  logic sw_req,
    output logic run
);
    localparam int CNT_W = $clog2(MIN_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(MIN_CYC);

    logic             req;
    logic [CNT_W-1:0] cnt;

    assign req = hw_req || sw_req;

    always_ff @(posedge clk) begin
        if (req) begin
            cnt <= '0;
            run <= 1'b0;
        end else begin
            if (cnt != CNT_TOP) cnt <= cnt + 1'b1;
            run <= (int'(cnt) >= MIN_CYC - 1);
        end
    end

    // any request forces the gate shut at the next edge
    p_req_blocks_r1: assert property (@(posedge clk) req |=> !run);
    // a sw request alone also restarts the gate
    p_sw_restart_r2: assert property (@(posedge clk) sw_req |=> (!run && cnt == '0));

endmodule

// File: rtl/ulpi_bus_ctl.sv
module ulpi_bus_ctl
    import ulpi_link_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  phy_side_t         phy,
    output logic              phy_stp,
    output logic [BYTE_W-1:0] dat_o,
    output logic              dat_oe,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_valid,
    input  logic              tx_last,
    output logic              tx_ready,
    output logic              tx_abort,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid
);
    tx_state_e state;
    logic      dir_q;
    logic      owned;

    assign owned = bus_owned(phy.dir, dir_q);

    always_ff @(posedge clk) begin
        dir_q <= phy.dir;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= TX_IDLE;
            tx_abort <= 1'b0;
        end else begin
            tx_abort <= (state == TX_SEND) && phy.dir;
            case (state)
                TX_IDLE: if (owned && tx_valid) state <= TX_SEND;
                TX_SEND: begin
                    if (phy.dir)                           state <= TX_IDLE;
                    else if (tx_valid && phy.nxt && tx_last) state <= TX_STOP;
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_valid <= 1'b0;
            rx_data  <= '0;
        end else begin
            rx_valid <= phy.dir && dir_q && phy.nxt;
            if (phy.dir && dir_q && phy.nxt) rx_data <= phy.data;
        end
    end

    always_comb begin
        phy_stp  = rst || (state == TX_STOP);
        dat_oe   = owned;
        dat_o    = (state == TX_SEND) ? tx_data : '0;
        tx_ready = (state == TX_SEND) && !phy.dir && phy.nxt;
    end

    p_oe_off_r4: assert property (@(posedge clk) disable iff (rst) phy.dir |-> !dat_oe);
    p_turn_r4:   assert property (@(posedge clk) disable iff (rst) $fell(phy.dir) |-> !dat_oe);
    p_idle_low_r5: assert property (@(posedge clk) disable iff (rst)
        (dat_oe && state != TX_SEND) |-> (dat_o == '0));
    p_ready_r6:  assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> (dat_oe && phy.nxt));
    p_stp_once_r7: assert property (@(posedge clk) disable iff (rst)
        (state == TX_STOP) |=> !phy_stp);
    p_stp_data_r7: assert property (@(posedge clk) disable iff (rst)
        phy_stp |-> (dat_o == '0));
    p_abort_r8:  assert property (@(posedge clk) disable iff (rst)
        (state == TX_SEND && phy.dir) |=> (tx_abort && state == TX_IDLE));
    p_rx_src_r9: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(phy.dir && phy.nxt));
    p_rx_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !phy.dir |=> !rx_valid);

endmodule

// File: rtl/ulpi_link.sv
module ulpi_link
    import ulpi_link_pkg::*;
#(
    parameter int MIN_CYC = 12
) (
    input  logic              clk,
    input  logic              hw_rst_req,
    input  logic              sw_rst_req,
    input  logic              phy_dir,
    input  logic              phy_nxt,
    output logic              phy_stp,
    input  logic [BYTE_W-1:0] dat_i,
    output logic [BYTE_W-1:0] dat_o,
    output logic              dat_oe,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_valid,
    input  logic              tx_last,
    output logic              tx_ready,
    output logic              tx_abort,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              core_rst_done
);
    logic      run;
    logic      core_rst;
    phy_side_t phy;

    assign phy           = '{dir: phy_dir, nxt: phy_nxt, data: dat_i};
    assign core_rst      = hw_rst_req || sw_rst_req || !run;
    assign core_rst_done = run;

    ulpi_rst_gate #(.MIN_CYC(MIN_CYC)) u_gate (
        .clk    (clk),
        .hw_req (hw_rst_req),
        .sw_req (sw_rst_req),
        .run    (run)
    );

    ulpi_bus_ctl u_bus (
        .clk      (clk),
        .rst      (core_rst),
        .phy      (phy),
        .phy_stp  (phy_stp),
        .dat_o    (dat_o),
        .dat_oe   (dat_oe),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_last  (tx_last),
        .tx_ready (tx_ready),
        .tx_abort (tx_abort),
        .rx_data  (rx_data),
        .rx_valid (rx_valid)
    );

    // gate output and bus stop line come from separate modules
    p_stp_in_rst_r3: assert property (@(posedge clk) disable iff (hw_rst_req)
        !core_rst_done |-> phy_stp);

endmodule

// File: tb/sim_ulpi_link.sv
module sim_ulpi_link;
    logic       clk = 1'b0;
    logic       hw_rst_req = 1'b1, sw_rst_req = 1'b0;
    logic       phy_dir = 1'b0, phy_nxt = 1'b0;
    logic [7:0] dat_i = 8'h00, tx_data = 8'h00;
    logic       tx_valid = 1'b0, tx_last = 1'b0;
    logic       phy_stp, dat_oe, tx_ready, tx_abort, rx_valid, core_rst_done;
    logic [7:0] dat_o, rx_data;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    ulpi_link u0 (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [7:0] byte_of(input int pkt, input int idx);
        return 8'((pkt * 37 + idx * 11 + 5) & 8'hFF);
    endfunction

    function automatic bit exp_rx(input bit dir_now, input bit dir_prev, input bit nxt);
        return dir_now && dir_prev && nxt;
    endfunction

    function automatic bit exp_oe(input bit dir_now, input bit dir_prev);
        return !dir_now && !dir_prev;
    endfunction

    initial begin
        #(8 * 150000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        bit dprev;
        void'($urandom(32'd1234));
        @(negedge clk);
        repeat (3) tick();
        // reset state
        chk(core_rst_done == 1'b0, "R1", core_rst_done, 0);
        chk(phy_stp == 1'b1, "R3", phy_stp, 1);
        chk(dat_oe == 1'b1 && dat_o == 8'h00, "R5", dat_o, 0);

        // release and count 12 edges
        hw_rst_req = 1'b0;
        for (int i = 1; i <= 12; i++) begin
            tick();
            if (i < 12) begin
                chk(core_rst_done == 1'b0, "R1", core_rst_done, 0);
                chk(phy_stp == 1'b1, "R3", phy_stp, 1);
            end else begin
                chk(core_rst_done == 1'b1, "R1", core_rst_done, 1);
                chk(phy_stp == 1'b0, "R3", phy_stp, 0);
            end
        end

        // sw pulse while running, then a restart mid-count
        sw_rst_req = 1'b1; tick(); sw_rst_req = 1'b0;
        chk(core_rst_done == 1'b0, "R2", core_rst_done, 0);
        chk(phy_stp == 1'b1, "R3", phy_stp, 1);
        repeat (5) tick();
        hw_rst_req = 1'b1; tick(); hw_rst_req = 1'b0;
        for (int i = 1; i <= 12; i++) begin
            tick();
            chk(core_rst_done == (i == 12), "R2", core_rst_done, int'(i == 12));
        end

        // idle ownership
        chk(dat_oe == 1'b1 && dat_o == 8'h00, "R5", {dat_oe, dat_o}, 9'h100);

        // directed two-byte transmit
        tx_valid = 1'b1; tx_data = 8'hA5; tx_last = 1'b0; phy_nxt = 1'b0;
        tick();
        #1 chk(dat_o == 8'hA5 && dat_oe, "R6", dat_o, 8'hA5);
        chk(tx_ready == 1'b0, "R6", tx_ready, 0);
        @(negedge clk);
        phy_nxt = 1'b1;
        #1 chk(tx_ready == 1'b1, "R6", tx_ready, 1);
        tick();
        tx_data = 8'h3C; tx_last = 1'b1;
        #1 chk(dat_o == 8'h3C && tx_ready, "R6", dat_o, 8'h3C);
        tick();
        tx_valid = 1'b0; tx_last = 1'b0; phy_nxt = 1'b0;
        #1 chk(phy_stp == 1'b1 && dat_o == 8'h00, "R7", {phy_stp, dat_o}, 9'h100);
        tick();
        chk(phy_stp == 1'b0, "R7", phy_stp, 0);

        // abort by direction change
        tx_valid = 1'b1; tx_data = 8'h77; tx_last = 1'b0;
        tick();
        phy_dir = 1'b1; phy_nxt = 1'b1;
        #1 chk(dat_oe == 1'b0 && tx_ready == 1'b0, "R8", {dat_oe, tx_ready}, 0);
        chk(dat_oe == 1'b0, "R4", dat_oe, 0);
        tick();
        tx_valid = 1'b0; phy_nxt = 1'b0;
        chk(tx_abort == 1'b1 && phy_stp == 1'b0, "R8", {tx_abort, phy_stp}, 2'b10);
        chk(rx_valid == 1'b0, "R9", rx_valid, 0);
        tick();
        chk(tx_abort == 1'b0 && dat_o == 8'h00, "R8", tx_abort, 0);

        // receive directed: dir held high
        dat_i = 8'h55; phy_nxt = 1'b1;
        tick();
        chk(rx_valid == 1'b1 && rx_data == 8'h55, "R9", rx_data, 8'h55);
        phy_nxt = 1'b0;
        tick();
        chk(rx_valid == 1'b0, "R9", rx_valid, 0);

        // turnaround back to link
        phy_dir = 1'b0; phy_nxt = 1'b1; dat_i = 8'hEE;
        #1 chk(dat_oe == 1'b0, "R4", dat_oe, 0);
        tick();
        chk(rx_valid == 1'b0, "R10", rx_valid, 0);
        chk(dat_oe == 1'b1 && dat_o == 8'h00, "R5", dat_o, 0);
        tick();
        chk(rx_valid == 1'b0, "R10", rx_valid, 0);
        phy_nxt = 1'b0;

        // directed: dir rises with nxt, turnaround cycle captures nothing
        phy_dir = 1'b1; phy_nxt = 1'b1; dat_i = 8'h99;
        tick();
        chk(rx_valid == 1'b0, "R9", rx_valid, 0);
        phy_dir = 1'b0; phy_nxt = 1'b0;
        tick(); tick();

        // random transmit packets
        for (int p = 0; p < 20; p++) begin
            int len, idx;
            len = 1 + int'($urandom % 5);
            idx = 0;
            tx_valid = 1'b1; tx_data = byte_of(p, 0); tx_last = (len == 1);
            tick();
            while (idx < len) begin
                phy_nxt = $urandom % 2;
                #1 chk(dat_o == byte_of(p, idx), "R6", dat_o, byte_of(p, idx));
                chk(tx_ready == phy_nxt, "R6", tx_ready, phy_nxt);
                chk(phy_stp == 1'b0, "R7", phy_stp, 0);
                tick();
                if (phy_nxt) begin
                    idx++;
                    if (idx < len) begin
                        tx_data = byte_of(p, idx); tx_last = (idx == len - 1);
                    end else begin
                        tx_valid = 1'b0; tx_last = 1'b0;
                    end
                end
            end
            phy_nxt = 1'b0;
            #1 chk(phy_stp == 1'b1 && dat_o == 8'h00, "R7", {phy_stp, dat_o}, 9'h100);
            tick();
            chk(phy_stp == 1'b0, "R7", phy_stp, 0);
        end

        // random receive / direction traffic, link idle
        dprev = 1'b0;
        for (int k = 0; k < 400; k++) begin
            bit d, n, e;
            logic [7:0] b;
            d = ($urandom % 4) != 0;
            n = $urandom % 2;
            b = 8'($urandom);
            phy_dir = d; phy_nxt = n; dat_i = b;
            e = exp_rx(d, dprev, n);
            #1 chk(dat_oe == exp_oe(d, dprev), "R4", dat_oe, exp_oe(d, dprev));
            tick();
            if (d) chk(rx_valid == e && (!e || rx_data == b), "R9", {rx_valid, rx_data}, {e, b});
            else   chk(rx_valid == 1'b0, "R10", rx_valid, 0);
            dprev = d;
        end

        finished = 1;
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule